// File: doc/BRIEF.md
# Watchdog Timer with Reset Output

This block is an 8-bit up-counting watchdog. Software turns it on by writing a control byte that holds the watchdog mode bit and the enable bit. From then on the counter steps once for every pulse on a tick-enable input. Software must reload the counter, usually with zero, before it passes its top value. If the counter wraps while watchdog mode is on, the block raises a timed overflow output and sets a sticky overflow flag. When the reset-enable bit is set, it also raises a longer internal reset output.

All writes to the block are 16-bit words. The upper byte is a key that picks the operation and the lower byte carries the data. A word whose key is not recognised changes nothing. Reads are single bytes, selected by offset, and come back on the clock edge after the offset is applied. The synchronous reset input acts as the external reset. It clears every register and takes priority over a watchdog overflow in the same cycle.

Top module: `wdt_core`

## Requirements
- R1: The overflow outputs and the flag respond only when both control bits are 1: bit 6 (watchdog mode) and bit 5 (enable). With enable 1 and mode 0, the counter still counts and wraps, but ovf_o, irst_o and the flag stay 0.
- R2: While enable is 1, the counter rises by 1 (mod 256) on each cycle where tick_i is 1. While enable is 0, the counter is held at 0.
- R3: A write to offset 0xC with key 0x5A loads the lower byte into the counter. A load takes priority over a tick in the same cycle. Reloading the counter at intervals shorter than 256 ticks prevents any overflow.
- R4: When a tick takes the counter from 0xFF to 0x00 in watchdog mode with reset-enable 0, ovf_o goes high from the next clock edge for exactly 130 cycles, and irst_o stays 0.
- R5: In the same situation with reset-enable 1, ovf_o is high for exactly 132 cycles. irst_o rises in the same cycle as ovf_o and is high for exactly 518 cycles.
- R6: The overflow flag is set by each watchdog overflow and stays set until the keyed clear operation.
- R7: A write to offset 0xE with key 0xA5 and lower byte 0x00 clears the flag. A write to offset 0xE with key 0x5A loads reset-enable from bit 6 of the lower byte, and this write never sets the flag.
- R8: A write is ignored and changes no register in these cases: its key is neither 0xA5 nor 0x5A, or it has key 0xA5 at offset 0xE with a nonzero lower byte.
- R9: When rst is high in the same cycle as an overflowing tick, the reset wins. The flag, ovf_o and irst_o all stay 0.
- R10: Read map, valid one cycle after rd_addr_i is applied:
  - offset 0xC returns the control byte (bit 6 mode, bit 5 enable, other bits 0);
  - offset 0xD returns the counter;
  - offset 0xF returns the reset control byte (bit 7 flag, bit 6 reset-enable, other bits 0);
  - any other offset returns 0.
  After reset, all of these read 0.
- R11: A write to offset 0xC with key 0xA5 loads watchdog mode from bit 6 and enable from bit 5 of the lower byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high external reset |
| tick_i | input | 1 | Counter tick enable |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | 4 | Write offset |
| wr_data_i | input | 16 | Key byte (upper) and data byte (lower) |
| rd_addr_i | input | 4 | Read offset |
| rd_data_o | output | 8 | Registered read data |
| ovf_o | output | 1 | Timed overflow pulse |
| irst_o | output | 1 | Timed internal reset pulse |

## Verification
Some properties are checked by assertions on every cycle:
- the counter holding at zero when disabled and stepping by one per tick;
- that unrecognised keys leave the control bits alone;
- that the flag stays set until it is cleared;
- that irst_o rises only together with ovf_o and only when reset-enable was set;
- that ovf_o never rises outside watchdog mode.

Other behaviour can only be shown by the bench scenarios:
- the exact pulse lengths of 130, 132 and 518 cycles;
- that random periodic reloads prevent any overflow;
- the outcome when the external reset meets an overflowing tick in the same cycle.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;
  localparam logic [ADDR_W-1:0] OFS_CTRL    = 4'hC;
  localparam logic [ADDR_W-1:0] OFS_CNT     = 4'hD;
  localparam logic [ADDR_W-1:0] OFS_RCTL_WR = 4'hE;
  localparam logic [ADDR_W-1:0] OFS_RCTL_RD = 4'hF;
  localparam logic [DATA_W-1:0] KEY_A = 8'hA5;
  localparam logic [DATA_W-1:0] KEY_B = 8'h5A;
  localparam int MODE_BIT = 6;
  localparam int EN_BIT   = 5;
  localparam int FLAG_BIT = 7;
  localparam int RSTE_BIT = 6;
endpackage

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             wd_mode,
  input  logic             tick,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_val,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf_evt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (!en)  cnt <= '0;
    else if (ld)   cnt <= ld_val;
    else if (tick) cnt <= cnt + 1'b1;
  end

  assign ovf_evt = en && wd_mode && tick && !ld && (cnt == CNT_MAX);

  p_hold_zero_r2: assert property (@(posedge clk) disable iff (rst)
    !en |=> (cnt == '0));
  p_step_r2: assert property (@(posedge clk) disable iff (rst)
    (en && tick && !ld) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));
  p_load_r3: assert property (@(posedge clk) disable iff (rst)
    (en && ld) |=> (cnt == $past(ld_val)));
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
  parameter int LEN_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [LEN_W-1:0] len,
  output logic             active
);
  logic [LEN_W-1:0] rem;

  always_ff @(posedge clk) begin
    if (rst) begin
      rem    <= '0;
      active <= 1'b0;
    end else if (start) begin
      rem    <= len;
      active <= (len != '0);
    end else begin
      if (rem != '0) rem <= rem - 1'b1;
      active <= (rem > LEN_W'(1));
    end
  end

  p_start_raises_r4: assert property (@(posedge clk) disable iff (rst)
    (start && len != '0) |=> active);
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [2*DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0]   rd_addr,
  input  logic [CNT_W-1:0]    cnt,
  input  logic                ovf_evt,
  output logic                wd_mode,
  output logic                en,
  output logic                rste,
  output logic                flag,
  output logic                cnt_ld,
  output logic [CNT_W-1:0]    cnt_ld_val,
  output logic [DATA_W-1:0]   rd_data
);
  logic [DATA_W-1:0] key, lo;
  logic ctrl_wr, rste_wr, flag_clr;
  logic [DATA_W-1:0] rd_next;

  assign key = wr_data[2*DATA_W-1:DATA_W];
  assign lo  = wr_data[DATA_W-1:0];

  assign ctrl_wr    = wr_en && (wr_addr == OFS_CTRL)    && (key == KEY_A);
  assign cnt_ld     = wr_en && (wr_addr == OFS_CTRL)    && (key == KEY_B);
  assign rste_wr    = wr_en && (wr_addr == OFS_RCTL_WR) && (key == KEY_B);
  assign flag_clr   = wr_en && (wr_addr == OFS_RCTL_WR) && (key == KEY_A) && (lo == '0);
  assign cnt_ld_val = CNT_W'(lo);

  always_ff @(posedge clk) begin
    if (rst) begin
      wd_mode <= 1'b0;
      en      <= 1'b0;
      rste    <= 1'b0;
      flag    <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        wd_mode <= lo[MODE_BIT];
        en      <= lo[EN_BIT];
      end
      if (rste_wr) rste <= lo[RSTE_BIT];
      if (ovf_evt)       flag <= 1'b1;
      else if (flag_clr) flag <= 1'b0;
    end
  end

  always_comb begin
    rd_next = '0;
    case (rd_addr)
      OFS_CTRL: begin
        rd_next[MODE_BIT] = wd_mode;
        rd_next[EN_BIT]   = en;
      end
      OFS_CNT: rd_next = DATA_W'(cnt);
      OFS_RCTL_RD: begin
        rd_next[FLAG_BIT] = flag;
        rd_next[RSTE_BIT] = rste;
      end
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_next;
  end

  p_badkey_ignored_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && key != KEY_A && key != KEY_B) |=> $stable({wd_mode, en, rste}));
  p_flag_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (flag && !flag_clr) |=> flag);
  p_rste_wr_no_flag_r7: assert property (@(posedge clk) disable iff (rst)
    (!flag && rste_wr && !ovf_evt) |=> !flag);
endmodule

// File: rtl/wdt_core.sv
module wdt_core
  import wdt_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int OVF_LEN_RE = 132,
  parameter int OVF_LEN_NR = 130,
  parameter int IRST_LEN   = 518
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick_i,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   wr_addr_i,
  input  logic [2*DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0]   rd_addr_i,
  output logic [DATA_W-1:0]   rd_data_o,
  output logic                ovf_o,
  output logic                irst_o
);
  localparam int MAX_LEN = (IRST_LEN > OVF_LEN_RE) ? IRST_LEN : OVF_LEN_RE;
  localparam int LEN_W   = $clog2(MAX_LEN + 1);
  localparam logic [LEN_W-1:0] L_RE   = LEN_W'(OVF_LEN_RE);
  localparam logic [LEN_W-1:0] L_NR   = LEN_W'(OVF_LEN_NR);
  localparam logic [LEN_W-1:0] L_IRST = LEN_W'(IRST_LEN);

  logic wd_mode, en, rste, flag, cnt_ld, ovf_evt;
  logic [CNT_W-1:0] cnt, cnt_ld_val;

  wdt_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en_i), .wr_addr(wr_addr_i),
    .wr_data(wr_data_i), .rd_addr(rd_addr_i), .cnt(cnt), .ovf_evt(ovf_evt),
    .wd_mode(wd_mode), .en(en), .rste(rste), .flag(flag), .cnt_ld(cnt_ld),
    .cnt_ld_val(cnt_ld_val), .rd_data(rd_data_o)
  );

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .en(en), .wd_mode(wd_mode), .tick(tick_i),
    .ld(cnt_ld), .ld_val(cnt_ld_val), .cnt(cnt), .ovf_evt(ovf_evt)
  );

  wdt_pulse #(.LEN_W(LEN_W)) u_ovf_pulse (
    .clk(clk), .rst(rst), .start(ovf_evt), .len(rste ? L_RE : L_NR),
    .active(ovf_o)
  );

  wdt_pulse #(.LEN_W(LEN_W)) u_irst_pulse (
    .clk(clk), .rst(rst), .start(ovf_evt && rste), .len(L_IRST),
    .active(irst_o)
  );

  p_irst_with_ovf_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(irst_o) |-> ovf_o);
  p_irst_needs_rste_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(irst_o) |-> $past(rste));
  p_flag_on_ovf_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_o) |-> flag);
  p_wd_mode_only_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_o) |-> $past(wd_mode && en));
endmodule

// File: tb/wdt_core_tb_top.sv
module wdt_core_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_i = 1'b0;
  logic wr_en_i = 1'b0;
  logic [3:0] wr_addr_i = '0;
  logic [15:0] wr_data_i = '0;
  logic [3:0] rd_addr_i = '0;
  logic [7:0] rd_data_o;
  logic ovf_o, irst_o;

  int checks = 0, fails = 0;
  int ovf_run = 0, ovf_last = 0, ovf_rises = 0;
  int irst_run = 0, irst_last = 0, irst_rises = 0, rise_mism = 0;
  logic ovf_prev = 1'b0, irst_prev = 1'b0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdt_core dut_i (
    .clk(clk), .rst(rst), .tick_i(tick_i), .wr_en_i(wr_en_i),
    .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i),
    .rd_data_o(rd_data_o), .ovf_o(ovf_o), .irst_o(irst_o)
  );

  always @(negedge clk) begin
    if (ovf_o) ovf_run++;
    else if (ovf_run != 0) begin ovf_last = ovf_run; ovf_run = 0; end
    if (irst_o) irst_run++;
    else if (irst_run != 0) begin irst_last = irst_run; irst_run = 0; end
    if (ovf_o && !ovf_prev) ovf_rises++;
    if (irst_o && !irst_prev) begin
      irst_rises++;
      if (!(ovf_o && !ovf_prev)) rise_mism++;
    end
    ovf_prev = ovf_o;
    irst_prev = irst_o;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(posedge clk); @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output int v);
    rd_addr_i = a;
    @(posedge clk); @(negedge clk);
    v = rd_data_o;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick_i = 1'b1; @(posedge clk); @(negedge clk);
    end
    tick_i = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int wrap8(input int v);
    return v & 8'hFF;
  endfunction

  task automatic report;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog (all R): actual=timeout expected=completion");
      report();
      $finish;
    end
  end

  initial begin
    int v, model, nt, r0, t0;
    void'($urandom(32'd1234));
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R10 reset state
    rd(4'hC, v); chk("R10 ctrl after reset", v, 0);
    rd(4'hD, v); chk("R10 cnt after reset", v, 0);
    rd(4'hF, v); chk("R10 rctl after reset", v, 0);
    chk("R10 outputs after reset", {ovf_o, irst_o}, 0);

    // R2 disabled counter holds zero
    ticks(10); rd(4'hD, v); chk("R2 hold at zero when disabled", v, 0);

    // R11 control write, R8 bad keys
    wr(4'hC, 16'hA560); rd(4'hC, v); chk("R11 control write", v, 8'h60);
    wr(4'hC, 16'h3300); rd(4'hC, v); chk("R8 bad key ctrl ignored", v, 8'h60);
    wr(4'hE, 16'h1240); rd(4'hF, v); chk("R8 bad key rctl ignored", v, 0);
    rd(4'h3, v); chk("R10 unmapped offset", v, 0);

    // R2 random ticks
    model = 0;
    for (int i = 0; i < 40; i++) begin
      tick_i = 1'($urandom % 2);
      if (tick_i) model++;
      @(posedge clk); @(negedge clk);
    end
    tick_i = 1'b0;
    rd(4'hD, v); chk("R2 random tick count", v, wrap8(model));

    // R3 periodic reload prevents overflow
    r0 = ovf_rises;
    nt = 0;
    for (int k = 0; k < 8; k++) begin
      wr(4'hC, 16'h5A00);
      nt = 50 + ($urandom % 151);
      ticks(nt);
    end
    rd(4'hD, v); chk("R3 count since last reload", v, wrap8(nt));
    chk("R3 no overflow with reloads", ovf_rises - r0, 0);
    rd(4'hF, v); chk("R3 flag clear with reloads", v, 0);
    wr(4'hC, 16'h5A77); rd(4'hD, v); chk("R3 counter load value", v, 8'h77);

    // R4 overflow, reset-enable 0
    r0 = irst_rises;
    wr(4'hC, 16'h5AF0); ticks(16); idle(600);
    chk("R4 ovf pulse length 130", ovf_last, 130);
    chk("R4 no internal reset", irst_rises - r0, 0);
    rd(4'hF, v); chk("R6 flag set after overflow", v, 8'h80);
    idle(300); rd(4'hF, v); chk("R6 flag remains set", v, 8'h80);

    // R8 / R7 keyed reset-control writes
    wr(4'hE, 16'hA501); rd(4'hF, v); chk("R8 clear with nonzero low ignored", v, 8'h80);
    wr(4'hE, 16'hA500); rd(4'hF, v); chk("R7 flag cleared", v, 0);
    wr(4'hE, 16'h5AC0); rd(4'hF, v); chk("R7 rste set, flag not set", v, 8'h40);

    // R5 overflow, reset-enable 1
    r0 = irst_rises;
    wr(4'hC, 16'h5AF0); ticks(16); idle(700);
    chk("R5 ovf pulse length 132", ovf_last, 132);
    chk("R5 irst pulse length 518", irst_last, 518);
    chk("R5 one irst pulse", irst_rises - r0, 1);
    chk("R5 irst rises with ovf", rise_mism, 0);
    rd(4'hF, v); chk("R6 flag and rste", v, 8'hC0);

    // R1 interval mode gives no overflow outputs
    wr(4'hE, 16'hA500);
    wr(4'hC, 16'hA520);
    r0 = ovf_rises;
    wr(4'hC, 16'h5AF0); ticks(20); idle(5);
    chk("R1 no ovf in interval mode", ovf_rises - r0, 0);
    rd(4'hF, v); chk("R1 flag stays clear", v, 8'h40);
    rd(4'hD, v); chk("R1 counter wraps", v, wrap8(8'hF0 + 20));

    // R9 external reset wins over overflow
    wr(4'hC, 16'hA560);
    wr(4'hC, 16'h5AF0); ticks(15);
    rd(4'hD, v); chk("R9 counter at top", v, 8'hFF);
    r0 = ovf_rises; t0 = irst_rises;
    tick_i = 1'b1; rst = 1'b1;
    @(posedge clk); @(negedge clk);
    tick_i = 1'b0; rst = 1'b0;
    idle(5);
    chk("R9 no ovf pulse", ovf_rises - r0, 0);
    chk("R9 no irst pulse", irst_rises - t0, 0);
    rd(4'hF, v); chk("R9 flag cleared", v, 0);
    rd(4'hC, v); chk("R9 control cleared", v, 0);

    done = 1;
    report();
    $finish;
  end
endmodule